// File: doc/BRIEF.md
# Three-Wire Serial Host Controller

This block is the master end of a three-wire serial link to a timekeeping or scratchpad target. It drives a frame enable line (`sio_rst`) and a serial clock (`sio_sclk`). It also drives one data line, with the line's direction given by an output-enable. The direction switch itself is placed outside the block. The data line is presented as three separate signals: `sio_dout`, `sio_oe` and `sio_din`.

A user issues one request at a time. A request carries a bank select (RAM or clock registers), a 5-bit address, a read/write flag, a write byte and a burst length. The block builds the command byte and raises the enable while the serial clock is low. It then shifts the command out least significant bit first, followed by write data or by captured read data. Each read byte is handed back with a one-cycle strobe. During a write burst, the block pulses `wr_take` each time it latches the write byte. The user then presents the next byte.

The serial clock runs at a fixed fraction of the system clock. Each half of the serial clock lasts `DIV_HALF` system clock cycles.

Top module: `tw_host`

## Requirements
- R1: After synchronous reset, `sio_rst`, `sio_sclk`, `sio_oe`, `busy`, `done`, `rd_valid` and `wr_take` are all 0.
- R2: `sio_sclk` is 0 in the cycle `sio_rst` rises, and stays 0 whenever `sio_rst` is 0.
- R3: The command byte is sent first, least significant bit first, with one bit per serial-clock rising edge. Its bits are:
  - bit 7 = 1
  - bit 6 = 1 for RAM and 0 for clock registers
  - bits 5..1 = address
  - bit 0 = 1 for read and 0 for write

  `sio_oe` is 1 and `sio_dout` does not change while `sio_sclk` is high.
- R4: In a write, each data byte follows the command, least significant bit first. The byte is taken from `req_wdata`, and `wr_take` pulses for one cycle in the cycle after the byte is latched.
- R5: In a read, `sio_oe` falls together with the serial-clock falling edge that follows the eighth command bit, and stays 0 to the end of the transfer. The bit on `sio_din` is captured at each following rising edge, and the first captured bit is the least significant. Each completed byte appears on `rd_data`, with `rd_valid` high for one cycle.
- R6: Address 31 selects a burst of `req_len` data bytes, where a length of 0 counts as 1. Any other address transfers exactly one data byte, whatever `req_len` is.
- R7: During a transfer, each high level of `sio_sclk` and each low level of `sio_sclk` lasts exactly `DIV_HALF` system clock cycles.
- R8: A transfer ends with `sio_sclk` low for `DIV_HALF` cycles before `sio_rst` falls. `done` pulses for one cycle when `sio_rst` falls. `sio_rst` then stays low for at least `2*DIV_HALF` cycles before the next transfer.
- R9: `busy` rises in the same cycle as `sio_rst` and stays high through the end-of-transfer gap. A `req_valid` seen while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_ram | input | 1 | 1 = RAM bank, 0 = clock registers |
| req_addr | input | 5 | Register address, 31 = burst |
| req_read | input | 1 | 1 = read, 0 = write |
| req_wdata | input | 8 | Write byte, sampled at each byte start |
| req_len | input | LEN_W | Burst byte count (0 treated as 1) |
| busy | output | 1 | Transfer or end gap in progress |
| done | output | 1 | One-cycle pulse at end of transfer |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_data | output | 8 | Captured read byte |
| wr_take | output | 1 | Write byte was latched, present the next |
| sio_rst | output | 1 | Link frame enable |
| sio_sclk | output | 1 | Serial clock |
| sio_dout | output | 1 | Data out to the link |
| sio_oe | output | 1 | Data driver enable |
| sio_din | input | 1 | Data in from the link |

## Verification
The bench builds the block with `DIV_HALF` = 3 and `LEN_W` = 4. The odd, short divider keeps every clock level at a count that a wrong off-by-one would visibly change. The 4-bit length puts the longest burst, 15 bytes, within a few thousand cycles, so both the zero-length corner and the full-length corner of the burst counter are reached. A behavioural target in the bench decodes the command from the rising edges and drives read bits on falling edges. Its drive timing lets a capture taken on the wrong edge or in the wrong bit order show up as a data mismatch.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_LOW, S_HIGH, S_TAIL, S_GAP
  } tw_state_e;

  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] BURST_ADDR = 5'd31;

  function automatic logic [7:0] tw_cmd(input logic ram, input logic [ADDR_W-1:0] addr,
                                        input logic rd);
    return {1'b1, ram, addr, rd};
  endfunction
endpackage

// File: rtl/tw_tick.sv
module tw_tick #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST) && !clr;
endmodule

// File: rtl/tw_shift.sv
module tw_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_out,
  input  logic         shift_in,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)            q <= '0;
    else if (load)      q <= load_val;
    else if (shift_in)  q <= {din, q[W-1:1]};
    else if (shift_out) q <= {1'b0, q[W-1:1]};
  end
endmodule

// File: rtl/tw_host.sv
module tw_host
  import tw_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int LEN_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_ram,
  input  logic [4:0]       req_addr,
  input  logic             req_read,
  input  logic [7:0]       req_wdata,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             wr_take,
  output logic             sio_rst,
  output logic             sio_sclk,
  output logic             sio_dout,
  output logic             sio_oe,
  input  logic             sio_din
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  tw_state_e        st;
  logic [2:0]       bitc;
  logic [LEN_W-1:0] left;
  logic             in_cmd, rd_op, gapc;
  logic             tick, accept;
  logic             sh_load, sh_out, sh_in, last_bit;
  logic [7:0]       sh_val, sh_q;

  assign accept   = (st == S_IDLE) && req_valid;
  assign last_bit = (bitc == 3'd7);

  tw_tick #(.HALF(DIV_HALF)) u_tick (
    .clk(clk), .rst(rst), .clr(accept), .tick(tick)
  );

  // shifter control: command/write bits move at falls, read bits enter at rises
  always_comb begin
    sh_load = accept ||
              ((st == S_HIGH) && tick && last_bit && !rd_op && (in_cmd || left != ONE));
    sh_val  = accept ? tw_cmd(req_ram, req_addr, req_read) : req_wdata;
    sh_out  = (st == S_HIGH) && tick && !last_bit && (in_cmd || !rd_op);
    sh_in   = (st == S_LOW) && tick && !in_cmd && rd_op;
  end

  tw_shift #(.W(8)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .load_val(sh_val),
    .shift_out(sh_out), .shift_in(sh_in), .din(sio_din), .q(sh_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      bitc     <= '0;
      left     <= '0;
      in_cmd   <= 1'b0;
      rd_op    <= 1'b0;
      gapc     <= 1'b0;
      sio_rst  <= 1'b0;
      sio_sclk <= 1'b0;
      sio_oe   <= 1'b0;
      done     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      wr_take  <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      wr_take  <= (st == S_HIGH) && sh_load;
      unique case (st)
        S_IDLE: if (req_valid) begin
          st      <= S_LEAD;
          sio_rst <= 1'b1;
          sio_oe  <= 1'b1;
          bitc    <= '0;
          in_cmd  <= 1'b1;
          rd_op   <= req_read;
          if (req_addr == BURST_ADDR && req_len != '0) left <= req_len;
          else                                         left <= ONE;
        end
        S_LEAD, S_LOW: if (tick) begin
          sio_sclk <= 1'b1;
          st       <= S_HIGH;
        end
        S_HIGH: if (tick) begin
          sio_sclk <= 1'b0;
          st       <= S_LOW;
          if (!last_bit) begin
            bitc <= bitc + 1'b1;
          end else begin
            bitc <= '0;
            if (in_cmd) begin
              in_cmd <= 1'b0;
              if (rd_op) sio_oe <= 1'b0;
            end else begin
              if (rd_op) begin
                rd_valid <= 1'b1;
                rd_data  <= sh_q;
              end
              if (left == ONE) st <= S_TAIL;
              else             left <= left - 1'b1;
            end
          end
        end
        S_TAIL: if (tick) begin
          sio_rst <= 1'b0;
          sio_oe  <= 1'b0;
          done    <= 1'b1;
          gapc    <= 1'b0;
          st      <= S_GAP;
        end
        S_GAP: if (tick) begin
          if (gapc) st <= S_IDLE;
          else      gapc <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign sio_dout = sh_q[0];
endmodule

// File: rtl/tw_host_chk.sv
module tw_host_chk #(
  parameter int DIV_HALF = 4
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic rd_valid,
  input logic sio_rst,
  input logic sio_sclk,
  input logic sio_dout,
  input logic sio_oe
);
  logic        prev_sclk, prev_rst, seen;
  logic [15:0] lvl;

  // counts cycles a serial-clock level has been held since its last change
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sclk <= 1'b0;
      prev_rst  <= 1'b0;
      seen      <= 1'b0;
      lvl       <= '0;
    end else begin
      prev_sclk <= sio_sclk;
      prev_rst  <= sio_rst;
      if ((sio_sclk != prev_sclk) || (sio_rst && !prev_rst)) begin
        lvl  <= 16'd1;
        seen <= 1'b1;
      end else if (lvl != 16'hFFFF) begin
        lvl <= lvl + 16'd1;
      end
    end
  end

  p_sclk_low_at_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sio_rst) |-> !sio_sclk);

  p_sclk_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    !sio_rst |-> !sio_sclk);

  p_dout_stable_high_r3: assert property (@(posedge clk) disable iff (rst)
    (sio_oe && sio_sclk && $past(sio_sclk)) |-> $stable(sio_dout));

  p_rd_valid_released_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (busy && !sio_oe));

  p_level_width_r7: assert property (@(posedge clk) disable iff (rst)
    (seen && sio_rst && prev_rst && (sio_sclk != prev_sclk)) |-> (lvl == 16'(DIV_HALF)));

  p_done_on_rst_fall_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!sio_rst && $past(sio_rst)));

  p_busy_covers_frame_r9: assert property (@(posedge clk) disable iff (rst)
    sio_rst |-> busy);
endmodule

bind tw_host tw_host_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .rd_valid(rd_valid),
  .sio_rst(sio_rst), .sio_sclk(sio_sclk), .sio_dout(sio_dout), .sio_oe(sio_oe)
);

// File: tb/sim_tw_host.sv
`timescale 1ns/1ps
module sim_tw_host;
  localparam int HALF  = 3;
  localparam int LEN_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_ram = 1'b0, req_read = 1'b0;
  logic [4:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic busy, done, rd_valid, wr_take;
  logic [7:0] rd_data;
  logic sio_rst, sio_sclk, sio_dout, sio_oe;
  logic sio_din = 1'b0;

  always #5 clk = ~clk;

  tw_host #(.DIV_HALF(HALF), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ram(req_ram),
    .req_addr(req_addr), .req_read(req_read), .req_wdata(req_wdata),
    .req_len(req_len), .busy(busy), .done(done), .rd_valid(rd_valid),
    .rd_data(rd_data), .wr_take(wr_take), .sio_rst(sio_rst),
    .sio_sclk(sio_sclk), .sio_dout(sio_dout), .sio_oe(sio_oe), .sio_din(sio_din)
  );

  int vectors = 0, fails = 0, cyc = 0;
  bit finished = 0;

  function automatic logic [7:0] tpat(int i);
    return 8'h5A ^ 8'(i * 29);
  endfunction
  function automatic logic [7:0] wpat(int i);
    return 8'hC3 ^ 8'(i * 53);
  endfunction

  // behavioural target plus link monitor
  logic [7:0] cmd_seen, wbuf [0:15], rbuf [0:15];
  int rises = 0, last_rises = 0, transfers = 0, done_cnt = 0, rcount = 0;
  int wi = 0, wtakes = 0, lowc = 0, hic = 0, gap_min = 1000000;
  int r2_err = 0, oe_err = 0, hi_err = 0;
  logic p_rst = 1'b0, p_sclk = 1'b0, seen = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (sio_rst && !p_rst) begin
        transfers++;
        if (sio_sclk) r2_err++;
        if (seen && lowc < gap_min) gap_min = lowc;
        rises = 0;
        cmd_seen = '0;
      end
      if (!sio_rst && p_rst) begin
        last_rises = rises; lowc = 1; seen = 1'b1;
      end else if (!sio_rst) lowc++;
      if (!sio_rst && sio_sclk) r2_err++;
      if (sio_rst && sio_sclk && !p_sclk) begin
        if (rises < 8) begin
          if (!sio_oe) oe_err++;
          cmd_seen[rises] = sio_dout;
        end else if (!cmd_seen[0]) begin
          if (!sio_oe) oe_err++;
          wbuf[((rises - 8) / 8) % 16][(rises - 8) % 8] = sio_dout;
        end else if (sio_oe) oe_err++;
        rises++;
        hic = 1;
      end else if (sio_sclk) hic++;
      if (sio_rst && !sio_sclk && p_sclk) begin
        if (hic != HALF) hi_err++;
        if (cmd_seen[0] && rises >= 8)
          sio_din = tpat((rises - 8) / 8)[(rises - 8) % 8];
      end
      if (rd_valid) begin rbuf[rcount % 16] = rd_data; rcount++; end
      if (wr_take) begin wtakes++; wi++; req_wdata = wpat(wi); end
      if (done) done_cnt++;
      p_rst = sio_rst;
      p_sclk = sio_sclk;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic ram, input logic [4:0] addr, input logic rd,
                       input logic [LEN_W-1:0] len);
    while (busy) @(negedge clk);
    rcount = 0; wi = 0; wtakes = 0;
    req_wdata = wpat(0);
    req_ram = ram; req_addr = addr; req_read = rd; req_len = len;
    req_valid = 1'b1;
    @(negedge clk);
    while (!busy) @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset outputs", {sio_rst, sio_sclk, sio_oe, busy, done, rd_valid, wr_take}, 7'b0);
  endtask

  task automatic t_write_single;
    issue(1'b0, 5'd5, 1'b0, 4'd7);
    chk("R3 write command", cmd_seen, 8'h8A);
    chk("R6 non-burst length", last_rises, 16);
    chk("R4 write byte", wbuf[0], wpat(0));
    chk("R4 wr_take count", wtakes, 1);
  endtask

  task automatic t_read_single;
    issue(1'b1, 5'd3, 1'b1, 4'd0);
    chk("R3 read command", cmd_seen, 8'hC7);
    chk("R5 read byte count", rcount, 1);
    chk("R5 read byte", rbuf[0], tpat(0));
  endtask

  task automatic t_burst_read(input logic [LEN_W-1:0] len, input int nb);
    issue(1'b0, 5'd31, 1'b1, len);
    chk("R3 burst command", cmd_seen, 8'hBF);
    chk("R6 burst clocks", last_rises, 8 + 8 * nb);
    chk("R6 burst bytes", rcount, nb);
    for (int i = 0; i < nb; i++) chk("R5 burst data", rbuf[i], tpat(i));
  endtask

  task automatic t_burst_write;
    issue(1'b1, 5'd31, 1'b0, 4'd3);
    chk("R3 burst write command", cmd_seen, 8'hFE);
    chk("R6 burst write clocks", last_rises, 32);
    chk("R4 wr_take burst", wtakes, 3);
    for (int i = 0; i < 3; i++) chk("R4 burst write data", wbuf[i], wpat(i));
  endtask

  task automatic t_busy_ignore;
    int t0;
    t0 = transfers;
    while (busy) @(negedge clk);
    rcount = 0;
    req_ram = 1'b1; req_addr = 5'd9; req_read = 1'b1; req_len = 4'd0;
    req_valid = 1'b1;
    @(negedge clk);
    while (!busy) @(negedge clk);
    req_addr = 5'd2; req_read = 1'b0;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk("R9 busy during gap", busy, 1'b1);
    repeat (10 * HALF) @(negedge clk);
    chk("R9 request ignored", transfers - t0, 1);
    chk("R9 command unchanged", cmd_seen, 8'hD3);
    chk("R9 link idle after", sio_rst, 1'b0);
  endtask

  task automatic t_back_to_back;
    issue(1'b0, 5'd1, 1'b0, 4'd0);
    issue(1'b0, 5'd2, 1'b1, 4'd0);
    chk("R8 gap length", (gap_min >= 2 * HALF), 1'b1);
    chk("R5 back-to-back read", rbuf[0], tpat(0));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      finished = 1;
      vectors++; fails++;
      $display("FAIL watchdog all act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_write_single;
    t_read_single;
    t_burst_read(4'd5, 5);
    t_burst_read(4'd0, 1);
    t_burst_read(4'd15, 15);
    t_burst_write;
    t_busy_ignore;
    t_back_to_back;
    chk("R2 sclk low at start and idle", r2_err, 0);
    chk("R3 R5 driver enable phases", oe_err, 0);
    chk("R7 high level width", hi_err, 0);
    chk("R8 done per transfer", done_cnt, transfers);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule